// File: doc/BRIEF.md
# Tracking ADC Step Controller

This block is the digital half of a continuously tracking analog-to-digital converter. It holds an up/down count that feeds an external DAC directly. An external comparator sets its two outputs by comparing the analog input with the DAC output. In each enabled clock cycle the block moves the count one code toward the input. The count is never cleared between conversions, so a slowly moving input is followed with only a few steps per new result.

The comparator gives two signals. `up_in` means the analog input lies above the DAC level, and `down_in` means it lies below. When neither is high, the DAC matches the input, so the count holds and `sample_valid` marks the held code as a finished conversion. Both signals high together is an illegal combination: the count holds and a sticky error flag is raised. The count stops at both ends of the scale instead of wrapping. Reset places it at mid-scale. Deasserting `enable` freezes the count.

Top module: `tracking_adc_ctrl`

## Requirements
- R1: Synchronous active-high reset sets `dac_code` to mid-scale (2^(WIDTH-1), which is 128 for the default WIDTH of 8) and clears `sample_valid` and `conflict_err`.
- R2: At an edge where `enable`=1, `up_in`=1 and `down_in`=0, `dac_code` rises by exactly one code, unless it is already full scale.
- R3: At an edge where `enable`=1, `up_in`=0 and `down_in`=1, `dac_code` falls by exactly one code, unless it is already zero.
- R4: At an edge where `enable`=1 and both comparator inputs are 0, `dac_code` holds and `sample_valid` is 1 for the following cycle. In every other case `sample_valid` is 0 for that cycle.
- R5: At an edge where `enable`=1 and both comparator inputs are 1, `dac_code` holds and `conflict_err` becomes 1. It stays 1 until reset.
- R6: At full scale (2^WIDTH-1), an up request leaves the code at full scale; it never wraps to zero.
- R7: At zero, a down request leaves the code at zero; it never wraps to full scale.
- R8: While `enable`=0, `dac_code` is frozen, `sample_valid` is 0 and `conflict_err` keeps its value, whatever the comparator shows.
- R9: Conversions are not separated by any clearing of the count. A new conversion starts from the last result, so it completes in |input - previous code| steps plus one match cycle.
- R10: `dac_code` never changes by more than one code between consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows stepping; low freezes the count |
| up_in | input | 1 | Comparator: analog input above DAC level |
| down_in | input | 1 | Comparator: analog input below DAC level |
| dac_code | output | WIDTH | Count driving the DAC, also the conversion result |
| sample_valid | output | 1 | High for one cycle after a match; `dac_code` is a result |
| conflict_err | output | 1 | Sticky flag: both comparator outputs were seen high |

## Verification
Any wrong count shows on `dac_code` at the edge right after the faulty decision, because the count drives the port with no stage in between. A wrong direction decode makes the closed loop diverge or stall. That appears as a conversion whose cycle count differs from the code distance, or that never raises `sample_valid`. A wrap at either rail appears as a jump of full-scale size within one cycle. A lost error flag appears as soon as a legal step follows a conflict.

// File: rtl/tadc_pkg.sv
package tadc_pkg;

    // Decision taken from the comparator pair in one clock cycle.
    typedef enum logic [2:0] {
        STEP_FREEZE   = 3'd0,
        STEP_MATCH    = 3'd1,
        STEP_UP       = 3'd2,
        STEP_DOWN     = 3'd3,
        STEP_CONFLICT = 3'd4
    } step_e;

    function automatic step_e classify(input logic en, input logic above, input logic below);
        step_e s;
        if (!en)                s = STEP_FREEZE;
        else if (above && below) s = STEP_CONFLICT;
        else if (above)          s = STEP_UP;
        else if (below)          s = STEP_DOWN;
        else                     s = STEP_MATCH;
        return s;
    endfunction

    function automatic logic is_moving(input step_e s);
        return (s == STEP_UP) || (s == STEP_DOWN);
    endfunction

endpackage

// File: rtl/tadc_dir_decode.sv
module tadc_dir_decode
    import tadc_pkg::*;
(
    input  logic  enable,
    input  logic  above,
    input  logic  below,
    output step_e step
);
    always_comb begin
        step = classify(enable, above, below);
    end
endmodule

// File: rtl/tadc_sat_counter.sv
module tadc_sat_counter
    import tadc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    output logic [WIDTH-1:0] code
);
    localparam logic [WIDTH-1:0] CODE_MAX = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] CODE_MID = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

    logic             at_top, at_bottom;
    logic [WIDTH-1:0] code_nxt;

    always_comb begin
        at_top    = (code == CODE_MAX);
        at_bottom = (code == '0);
        code_nxt  = code;
        unique case (step)
            STEP_UP:   if (!at_top)    code_nxt = code + ONE;
            STEP_DOWN: if (!at_bottom) code_nxt = code - ONE;
            default:   code_nxt = code;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) code <= CODE_MID;
        else     code <= code_nxt;
    end

    assert_top_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (code == CODE_MAX) |=> (code != '0));
    assert_bottom_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (code == '0) |=> (code != CODE_MAX));
    assert_single_step_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((code - $past(code)) == '0 || (code - $past(code)) == ONE
                  || ($past(code) - code) == ONE));
    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !is_moving(step) |=> $stable(code));
    assert_up_moves_R2: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_UP && code != CODE_MAX) |=> (code == $past(code) + ONE));
    assert_down_moves_R3: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_DOWN && code != '0) |=> (code == $past(code) - ONE));
endmodule

// File: rtl/tadc_status.sv
module tadc_status
    import tadc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  step_e step,
    output logic  valid,
    output logic  err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            err   <= 1'b0;
        end else begin
            valid <= (step == STEP_MATCH);
            if (step == STEP_CONFLICT) err <= 1'b1;
        end
    end

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
    assert_err_on_conflict_R5: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_CONFLICT) |=> err);
    assert_valid_after_match_R4: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_MATCH) |=> valid);
    assert_valid_only_after_match_R4: assert property (@(posedge clk) disable iff (rst)
        (step != STEP_MATCH) |=> !valid);
endmodule

// File: rtl/tracking_adc_ctrl.sv
module tracking_adc_ctrl
    import tadc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             up_in,
    input  logic             down_in,
    output logic [WIDTH-1:0] dac_code,
    output logic             sample_valid,
    output logic             conflict_err
);
    localparam logic [WIDTH-1:0] CODE_MID = {1'b1, {(WIDTH-1){1'b0}}};

    step_e step;

    tadc_dir_decode u_decode (
        .enable (enable),
        .above  (up_in),
        .below  (down_in),
        .step   (step)
    );

    tadc_sat_counter #(.WIDTH(WIDTH)) u_count (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .code (dac_code)
    );

    tadc_status u_status (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .valid (sample_valid),
        .err   (conflict_err)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (dac_code == CODE_MID && !sample_valid && !conflict_err));
    assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> ($stable(dac_code) && !sample_valid && $stable(conflict_err)));
endmodule

// File: tb/tb_tracking_adc_ctrl.sv
module tb_tracking_adc_ctrl;
    localparam int WIDTH = 8;
    localparam int MID   = 128;
    localparam int FULL  = 255;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic up_in = 1'b0;
    logic down_in = 1'b0;
    logic [WIDTH-1:0] dac_code;
    logic sample_valid;
    logic conflict_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tracking_adc_ctrl #(.WIDTH(WIDTH)) dut (
        .clk(clk), .rst(rst), .enable(enable), .up_in(up_in), .down_in(down_in),
        .dac_code(dac_code), .sample_valid(sample_valid), .conflict_err(conflict_err)
    );

    typedef struct packed {
        logic       en;
        logic       up;
        logic       dn;
        logic [7:0] code;
        logic       valid;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b1, 1'b0, 8'd129, 1'b0},   // R2 step up
        '{1'b1, 1'b1, 1'b0, 8'd130, 1'b0},   // R2
        '{1'b1, 1'b0, 1'b1, 8'd129, 1'b0},   // R3 step down
        '{1'b1, 1'b0, 1'b0, 8'd129, 1'b1},   // R4 match
        '{1'b1, 1'b0, 1'b0, 8'd129, 1'b1},   // R4 repeated match
        '{1'b0, 1'b1, 1'b0, 8'd129, 1'b0},   // R8 frozen
        '{1'b0, 1'b0, 1'b1, 8'd129, 1'b0},   // R8 frozen
        '{1'b0, 1'b0, 1'b0, 8'd129, 1'b0},   // R8 no valid while off
        '{1'b1, 1'b0, 1'b1, 8'd128, 1'b0},   // R3
        '{1'b1, 1'b0, 1'b0, 8'd128, 1'b1}    // R4
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic en, input logic up, input logic dn);
        enable  = en;
        up_in   = up;
        down_in = dn;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        enable = 1'b0; up_in = 1'b0; down_in = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Closed loop with a comparator model; returns cycles until sample_valid.
    task automatic track(input int vin, input int limit, output int cycles, output int max_jump);
        int prev;
        cycles = 0;
        max_jump = 0;
        for (int i = 0; i < limit; i++) begin
            prev = int'(dac_code);
            tick(1'b1, vin > int'(dac_code), vin < int'(dac_code));
            cycles++;
            if ((int'(dac_code) - prev) > max_jump) max_jump = int'(dac_code) - prev;
            if ((prev - int'(dac_code)) > max_jump) max_jump = prev - int'(dac_code);
            if (sample_valid) break;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cyc, jump, wraps, prev;

        do_reset();
        check("R1 code", int'(dac_code), MID);
        check("R1 valid", int'(sample_valid), 0);
        check("R1 err", int'(conflict_err), 0);

        foreach (VEC[i]) begin
            tick(VEC[i].en, VEC[i].up, VEC[i].dn);
            check($sformatf("R2/R3/R4/R8 vec%0d code", i), int'(dac_code), int'(VEC[i].code));
            check($sformatf("R4/R8 vec%0d valid", i), int'(sample_valid), int'(VEC[i].valid));
        end

        // R5: conflict holds code and raises sticky error
        tick(1'b1, 1'b1, 1'b1);
        check("R5 code held", int'(dac_code), 128);
        check("R5 err set", int'(conflict_err), 1);
        check("R5 no valid", int'(sample_valid), 0);
        tick(1'b1, 1'b1, 1'b0);
        check("R5 err sticky", int'(conflict_err), 1);
        check("R2 step after conflict", int'(dac_code), 129);
        tick(1'b0, 1'b1, 1'b1);
        check("R8 err kept", int'(conflict_err), 1);
        check("R8 code frozen", int'(dac_code), 129);

        // R1: reset mid-stream
        do_reset();
        check("R1 code after rerun", int'(dac_code), MID);
        check("R1 err cleared", int'(conflict_err), 0);

        // R9: convergence from mid-scale, then from the previous result
        track(200, 400, cyc, jump);
        check("R9 first conversion code", int'(dac_code), 200);
        check("R9 first conversion cycles", cyc, 73);
        check("R10 first conversion max step", jump, 1);
        track(190, 400, cyc, jump);
        check("R9 continues from last result code", int'(dac_code), 190);
        check("R9 continues from last result cycles", cyc, 11);

        // R6: drive above full scale
        wraps = 0;
        for (int i = 0; i < 100; i++) begin
            prev = int'(dac_code);
            tick(1'b1, 1'b1, 1'b0);
            if (int'(dac_code) < prev) wraps++;
        end
        check("R6 top rail", int'(dac_code), FULL);
        check("R6 no wrap at top", wraps, 0);

        // R7: drive below zero
        wraps = 0;
        for (int i = 0; i < 300; i++) begin
            prev = int'(dac_code);
            tick(1'b1, 1'b0, 1'b1);
            if (int'(dac_code) > prev) wraps++;
        end
        check("R7 bottom rail", int'(dac_code), 0);
        check("R7 no wrap at bottom", wraps, 0);
        check("R7 no valid at rail", int'(sample_valid), 0);

        // R9: a new conversion starting at zero
        track(37, 400, cyc, jump);
        check("R9 from zero code", int'(dac_code), 37);
        check("R9 from zero cycles", cyc, 38);
        check("R10 max step", jump, 1);

        finish_run();
    end
endmodule